// File: doc/BRIEF.md
# Transposed-Form FIR Filter with Shared Odd Multiples

This block is a fixed-coefficient, fully parallel FIR filter. It takes one signed sample on every clock and delivers one filtered sample on every clock. Every tap sees the incoming sample in the same cycle, so there is no delay line on the input. The only delay storage is a registered summation chain that runs from the oldest tap to the newest.

There are no per-tap multipliers. A small pipelined shift-and-add network forms the odd multiples 3x, 13x, 21x and 37x of the sample once. Every tap then selects one of these products and applies its own fixed left shift and fixed sign. The tap coefficients, newest sample first, are 3, -13, 26, 37, 21 and -3:
- The taps with magnitude 3 share one product.
- The weight 26 is the shared 13x product shifted left by one bit.
- Negative weights subtract their product from the running sum instead of adding it.

A cycle whose valid input is low enters the filter as a zero sample. The output valid flag tracks the input valid flag through the pipeline.

Top module: `fir_transposed`

## Requirements
- R1: Each output equals the sum of c_k·x[n−k] for k = 0..5, with c = (3, −13, 26, 37, 21, −3), where x[n] is the sample that produces that output.
- R2: The result for a sample appears three rising edges after it is presented, counting the capturing edge. out_valid equals in_valid delayed by the same three edges.
- R3: A new sample is accepted on every consecutive clock edge, with no stall cycles between samples.
- R4: A sample presented while in_valid is 0 contributes exactly zero to every output, whatever its value.
- R5: While rst_n is 0 at a rising edge, all pipeline and chain state is cleared. After that edge, out_sample is 0 and out_valid is 0, and no sample taken before the reset affects later outputs.
- R6: out_sample is DATA_W+6+3 bits wide (25 by default). Constant full-scale input of either polarity yields the exact sum (−32768·71 or 32767·71) with no wraparound in any chain stage.
- R7: A lone unit sample yields, on consecutive outputs, the values 3, −13, 26, 37, 21, −3. These values come from the shared odd products, a one-bit shift for 26, and subtraction for the negative taps.
- R8: The multiple network delivers 3x, 13x, 21x and 37x of the (gated) input exactly two edges after the sample is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks in_sample as a real sample; when low, a zero sample is used |
| in_sample | input | DATA_W | Signed input sample, two's complement |
| out_valid | output | 1 | in_valid delayed by three edges |
| out_sample | output | ACC_W | Signed filtered output, two's complement |

## Verification
The hardest situation to reach from the ports is a reset that arrives while the chain still holds partial sums of earlier samples. The bench runs long random traffic first, so that every chain stage is non-zero, and then drops rst_n in the middle of the stream. The reference model discards its whole history at the reset, so any stale partial sum that survives in the design shows up as a mismatch once samples flow again. Runs of constant full-scale input drive every chain stage to its largest magnitude to expose wraparound, and a unit sample surrounded by invalid junk values isolates each tap's weight, sign and shift.

// File: rtl/fir_pkg.sv
// fir_pkg: shared constants and per-tap wiring for the transposed FIR.
// Assumes the coefficient set is fixed at design time; the tap table below
// maps each tap to a shared odd product, a left shift and a sign.
package fir_pkg;

    localparam int NUM_TAPS  = 6;
    localparam int COEF_BITS = 6;   // bits to carry the largest magnitude (37 < 64)
    localparam int MULT_LAT  = 2;   // pipeline stages in the multiple network
    localparam int NUM_PROD  = 4;   // number of distinct odd products

    typedef enum logic [1:0] {
        MUL3  = 2'd0,
        MUL13 = 2'd1,
        MUL21 = 2'd2,
        MUL37 = 2'd3
    } mult_sel_e;

    typedef struct packed {
        mult_sel_e   sel;    // which shared odd product
        logic [1:0]  shift;  // left shift applied before the chain
        logic        neg;    // subtract instead of add
    } tap_cfg_t;

    // Tap k weights the sample k cycles old: 3, -13, 26, 37, 21, -3
    function automatic tap_cfg_t tap_cfg(input int k);
        tap_cfg_t c;
        case (k)
            0:       c = '{sel: MUL3,  shift: 2'd0, neg: 1'b0};
            1:       c = '{sel: MUL13, shift: 2'd0, neg: 1'b1};
            2:       c = '{sel: MUL13, shift: 2'd1, neg: 1'b0};
            3:       c = '{sel: MUL37, shift: 2'd0, neg: 1'b0};
            4:       c = '{sel: MUL21, shift: 2'd0, neg: 1'b0};
            default: c = '{sel: MUL3,  shift: 2'd0, neg: 1'b1};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fir_mult_block.sv
// fir_mult_block: two-stage shift-and-add network that forms the odd
// multiples 3x, 13x, 21x and 37x of the input sample.
// Assumes PROD_W holds DATA_W + COEF_BITS so that 37x never wraps.
// Stage 1: 3x, 5x and a copy of x. Stage 2: 3x, 13x = 4*3x + x,
// 21x = 4*5x + x, 37x = 32x + 5x.
module fir_mult_block #(
    parameter int DATA_W = 16,
    parameter int PROD_W = DATA_W + fir_pkg::COEF_BITS
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic signed [DATA_W-1:0]                   x_in,
    output logic [fir_pkg::NUM_PROD-1:0][PROD_W-1:0]   prod
);
    import fir_pkg::*;

    logic signed [PROD_W-1:0] xe;
    logic signed [PROD_W-1:0] s1_x, s1_m3, s1_m5;
    logic signed [PROD_W-1:0] p3, p13, p21, p37;

    // sign-extend the sample to product width
    assign xe = PROD_W'(x_in);

    // stage 1: first level of adders
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_x  <= '0;
            s1_m3 <= '0;
            s1_m5 <= '0;
        end else begin
            s1_x  <= xe;
            s1_m3 <= (xe <<< 1) + xe;
            s1_m5 <= (xe <<< 2) + xe;
        end
    end

    // stage 2: second level of adders builds the remaining odd multiples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p3  <= '0;
            p13 <= '0;
            p21 <= '0;
            p37 <= '0;
        end else begin
            p3  <= s1_m3;
            p13 <= (s1_m3 <<< 2) + s1_x;
            p21 <= (s1_m5 <<< 2) + s1_x;
            p37 <= (s1_x <<< 5) + s1_m5;
        end
    end

    // pack products, indexed by mult_sel_e
    always_comb begin
        prod[MUL3]  = p3;
        prod[MUL13] = p13;
        prod[MUL21] = p21;
        prod[MUL37] = p37;
    end

    // counts edges since reset so checks look back only over valid history
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (!rst_n)                     warm <= '0;
        else if (warm != 2'(MULT_LAT))  warm <= warm + 2'd1;
    end

    // R8
    mult13_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'(MULT_LAT)) |-> ($signed(prod[MUL13]) == 13 * $past(x_in, 2)));

    // R8
    mult37_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'(MULT_LAT)) |-> ($signed(prod[MUL37]) == 37 * $past(x_in, 2)));

endmodule

// File: rtl/fir_tap.sv
// fir_tap: one stage of the transposed summation chain. It selects a shared
// odd product, shifts it left, and adds it to or subtracts it from the
// partial sum of the older neighbour, then registers the result.
// Assumes ACC_W leaves enough guard bits that the sum never wraps.
module fir_tap #(
    parameter int               PROD_W = 22,
    parameter int               ACC_W  = 25,
    parameter fir_pkg::tap_cfg_t CFG   = '0
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic [fir_pkg::NUM_PROD-1:0][PROD_W-1:0]   prod,
    input  logic signed [ACC_W-1:0]                    acc_in,
    output logic signed [ACC_W-1:0]                    acc_out
);
    logic signed [PROD_W-1:0] pick;
    logic signed [ACC_W-1:0]  term;
    logic signed [ACC_W:0]    wide;

    // select, widen, shift and apply the sign of this tap's weight
    always_comb begin
        pick = prod[CFG.sel];
        term = ACC_W'(pick) <<< CFG.shift;
        wide = CFG.neg ? ((ACC_W+1)'(acc_in) - (ACC_W+1)'(term))
                       : ((ACC_W+1)'(acc_in) + (ACC_W+1)'(term));
    end

    // chain register for this tap
    always_ff @(posedge clk) begin
        if (!rst_n) acc_out <= '0;
        else        acc_out <= wide[ACC_W-1:0];
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wide[ACC_W] == wide[ACC_W-1]);

endmodule

// File: rtl/fir_transposed.sv
// fir_transposed: full-parallel transposed-form FIR. The sample is gated by
// in_valid, fed to a shared multiple network, and every tap reads the
// products in the same cycle. Latency is MULT_LAT + 1 edges.
// Assumes one sample per clock and a synchronous active-low reset.
module fir_transposed #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = DATA_W + fir_pkg::COEF_BITS + $clog2(fir_pkg::NUM_TAPS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic signed [DATA_W-1:0]  in_sample,
    output logic                      out_valid,
    output logic signed [ACC_W-1:0]   out_sample
);
    import fir_pkg::*;

    localparam int PROD_W = DATA_W + COEF_BITS;
    localparam int LAT    = MULT_LAT + 1;

    logic signed [DATA_W-1:0]            x_g;
    logic [NUM_PROD-1:0][PROD_W-1:0]     prod;
    logic signed [ACC_W-1:0]             chain [NUM_TAPS+1];
    logic [LAT-1:0]                      vpipe;

    // invalid cycles enter the filter as zero samples
    assign x_g = in_valid ? in_sample : '0;

    fir_mult_block #(.DATA_W(DATA_W), .PROD_W(PROD_W)) mult_i (
        .clk   (clk),
        .rst_n (rst_n),
        .x_in  (x_g),
        .prod  (prod)
    );

    // the oldest tap starts from zero
    assign chain[NUM_TAPS] = '0;

    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        fir_tap #(.PROD_W(PROD_W), .ACC_W(ACC_W), .CFG(tap_cfg(k))) tap_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .prod    (prod),
            .acc_in  (chain[k+1]),
            .acc_out (chain[k])
        );
    end

    assign out_sample = chain[0];

    // carries the valid flag alongside the data latency
    always_ff @(posedge clk) begin
        if (!rst_n) vpipe <= '0;
        else        vpipe <= {vpipe[LAT-2:0], in_valid};
    end

    assign out_valid = vpipe[LAT-1];

    // counts edges since reset for the latency check window
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (!rst_n)                warm <= '0;
        else if (warm != 2'(LAT))  warm <= warm + 2'd1;
    end

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'(LAT)) |-> (out_valid == $past(in_valid, 3)));

    // R5
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (out_sample == '0 && !out_valid));

endmodule

// File: tb/fir_transposed_tb_top.sv
// Bench: behavioural convolution model over a history of gated samples,
// compared against the design on every falling edge.
module fir_transposed_tb_top;

    localparam int DATA_W = 16;
    localparam int ACC_W  = 25;
    localparam int HIST   = 8;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      in_valid = 1'b0;
    logic signed [DATA_W-1:0]  in_sample = '0;
    logic                      out_valid;
    logic signed [ACC_W-1:0]   out_sample;

    int  coef [6] = '{3, -13, 26, 37, 21, -3};
    int  hist [HIST];
    bit  vh   [HIST];
    int  checks = 0;
    int  fails  = 0;
    int  cyc    = 0;
    bit  started = 1'b0;
    bit  done    = 1'b0;

    fir_transposed #(.DATA_W(DATA_W), .ACC_W(ACC_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // reference history: a reset wipes it, otherwise gated samples shift in
    always @(posedge clk) begin
        for (int i = HIST-1; i > 0; i--) begin
            hist[i] <= rst_n ? hist[i-1] : 0;
            vh[i]   <= rst_n ? vh[i-1]   : 1'b0;
        end
        hist[0] <= (rst_n && in_valid) ? int'(in_sample) : 0;
        vh[0]   <= rst_n ? in_valid : 1'b0;
    end

    // R1, R2: per-cycle comparison against the convolution
    always @(negedge clk) begin
        if (started) begin
            int exp_y;
            exp_y = 0;
            for (int k = 0; k < 6; k++) exp_y += coef[k] * hist[2+k];
            check(int'(out_sample) == exp_y, "R1 convolution", int'(out_sample), exp_y);
            check(out_valid == vh[2], "R2 valid latency", out_valid, vh[2]);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d expected below 50000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic drive(input logic signed [DATA_W-1:0] x, input logic v);
        @(negedge clk);
        in_sample = x;
        in_valid  = v;
    endtask

    initial begin
        for (int i = 0; i < HIST; i++) begin
            hist[i] = 0;
            vh[i]   = 1'b0;
        end
        repeat (3) @(negedge clk);
        started = 1'b1;
        // R5: reset state
        check(out_sample == '0, "R5 reset output", int'(out_sample), 0);
        check(out_valid == 1'b0, "R5 reset valid", out_valid, 0);
        rst_n = 1'b1;
        repeat (8) drive('0, 1'b1);

        // R7, R8, R4, R2: unit sample followed by invalid junk
        drive(16'sd1, 1'b1);
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (i < 3) begin
                check(out_sample == '0, "R2 no early output", int'(out_sample), 0);
            end else begin
                check(int'(out_sample) == coef[i-3], "R7 R8 R4 impulse tap weight",
                      int'(out_sample), coef[i-3]);
                if (i == 3) check(out_valid == 1'b1, "R2 valid with first result", out_valid, 1);
            end
            in_sample = 16'sd12345;
            in_valid  = 1'b0;
        end
        repeat (8) drive('0, 1'b1);

        // R3: back-to-back random samples
        for (int i = 0; i < 300; i++) drive(DATA_W'($urandom), 1'b1);

        // R4: random samples with random valid
        for (int i = 0; i < 300; i++) drive(DATA_W'($urandom), 1'($urandom));

        // R6: constant full scale, both polarities
        for (int i = 0; i < 12; i++) drive(-16'sd32768, 1'b1);
        @(negedge clk);
        check(int'(out_sample) == -32768 * 71, "R6 negative full scale", int'(out_sample), -32768 * 71);
        for (int i = 0; i < 12; i++) drive(16'sd32767, 1'b1);
        @(negedge clk);
        check(int'(out_sample) == 32767 * 71, "R6 positive full scale", int'(out_sample), 32767 * 71);

        // R5: reset in the middle of traffic
        for (int i = 0; i < 40; i++) drive(DATA_W'($urandom), 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(out_sample == '0, "R5 mid-stream reset output", int'(out_sample), 0);
        check(out_valid == 1'b0, "R5 mid-stream reset valid", out_valid, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 60; i++) drive(DATA_W'($urandom), 1'b1);
        repeat (10) drive('0, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule